// File: doc/BRIEF.md
# Pre-trigger capture sequencer

This block fills a 640-entry array of 8-bit converter samples around a rising-edge trigger. The trigger sample lands in a chosen column, the columns to its left hold the samples that came just before it, and the columns to its right hold the samples that followed. A decimation code sets how many clock cycles pass between two samples. Each completed record is handed to a downstream display memory by raising a copy request until that side reports completion. The block then pauses before it re-arms. In single mode it stays paused until the mode is switched back.

All state advances on the falling clock edge, which gives the converter output half a cycle to settle before it is sampled. The array can be read at any time through a combinational read port. Run/stop and a settings-changed pulse both abandon the record in progress and restart from the initial state.

Top module: `capture_sequencer`

## Requirements
- R1: While `rst_n` is low, `copy_req` is low and every array entry reads 0.
- R2: `div_code` sets the sample interval in clock cycles: 0→INTV0, 1→INTV1, 2→INTV2, 3→INTV3, 4→INTV4, 5→INTV5. The defaults are 78125, 7813, 781, 78, 7 and 1. Codes 6 and 7 use INTV0. Samples taken during one record are exactly that many cycles apart.
- R3: A trigger is a sample that is at or above `trig_level` while the sample before it is below the level. The trigger is tested only once the write index has reached the trigger column, and the trigger sample is stored in that column.
- R4: When the trigger fires, columns 0 up to the trigger column minus 1 hold the samples that immediately preceded it, oldest at column 0. Before that point, a sample that does not trigger moves every pre-trigger entry one place toward column 0 and enters just left of the trigger column.
- R5: After the trigger, the following samples fill the next columns in order up to column 639. `copy_req` then rises.
- R6: `copy_req` stays high, and the array does not change, until `copy_done` is sampled high. `copy_req` is low at the next rising edge after that.
- R7: After the copy, the block waits DELAY_CYCLES cycles and then starts a new record when `single_mode` is 0.
- R8: With `single_mode` = 1, the block stays paused after the copy until `single_mode` returns to 0.
- R9: `run_stop` = 1 or `settings_chg` = 1 sends the block to its initial state and clears the interval counter, the write index and the stored previous sample. No record completes while `run_stop` is held.
- R10: A `trig_pos` above 639 acts as 639, and the record goes to copy as soon as the trigger fires.
- R11: With `trig_pos` = 0, the trigger sample is stored in column 0 and there is no pre-trigger history.
- R12: With `trig_level` = 0, no sample can trigger, because no previous sample is below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the state advances on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data | input | 8 | Converter sample bus |
| div_code | input | 3 | Time-base code, 0 (slowest) to 5 (fastest) |
| trig_level | input | 8 | Trigger threshold |
| trig_pos | input | 10 | Column that receives the trigger sample |
| single_mode | input | 1 | 1 = pause after each record, 0 = free running |
| run_stop | input | 1 | 1 = hold in the initial state |
| settings_chg | input | 1 | Restart pulse sent when a setting is edited |
| copy_done | input | 1 | Downstream copy finished |
| rd_addr | input | 10 | Array read address |
| copy_req | output | 1 | Record complete; request a copy |
| rd_data | output | 8 | Array entry at `rd_addr` |

## Verification
The embedded assertions check on every falling edge that a restart request clears the sequencer, that the write index stays inside the array, that entering the post-trigger phase happens one column past the trigger position on a sample at or above the level, that the copy phase is entered only from the last column, that the pause lasts at least the programmed delay, and that single mode never leaves the pause. Only the bench scenarios can show the array contents themselves. These are the exact pre-trigger ordering after many shifts, the sample spacing chosen by each code, the clamped and zero trigger columns, and the array staying frozen while the copy is pending. The bench drives a ramp so that every expected column value follows from the trigger column, the level and the interval.

// File: rtl/capture_sequencer.sv
module capture_sequencer #(
  parameter int NSAMP        = 640,
  parameter int DW           = 8,
  parameter int PW           = 10,
  parameter int INTV0        = 78125,
  parameter int INTV1        = 7813,
  parameter int INTV2        = 781,
  parameter int INTV3        = 78,
  parameter int INTV4        = 7,
  parameter int INTV5        = 1,
  parameter int DELAY_CYCLES = 10_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] adc_data,
  input  logic [2:0]    div_code,
  input  logic [DW-1:0] trig_level,
  input  logic [PW-1:0] trig_pos,
  input  logic          single_mode,
  input  logic          run_stop,
  input  logic          settings_chg,
  input  logic          copy_done,
  input  logic [PW-1:0] rd_addr,
  output logic          copy_req,
  output logic [DW-1:0] rd_data
);
  localparam int LAST = NSAMP - 1;
  localparam int MAXC = (DELAY_CYCLES > INTV0) ? DELAY_CYCLES : INTV0;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_INIT, S_COUNT, S_TRIG, S_COPY, S_DELAY} st_t;

  st_t           st;
  logic [CW-1:0] cnt, intv, intv_sel;
  logic [PW-1:0] idx;
  logic [DW-1:0] prev;
  logic [DW-1:0] mem [NSAMP];

  wire [PW-1:0] tp         = (int'(trig_pos) > LAST) ? PW'(LAST) : trig_pos;
  wire          force_init = run_stop | settings_chg;
  wire [CW-1:0] cnt_nx     = cnt + 1'b1;
  wire          take       = (st == S_COUNT || st == S_TRIG) && (cnt_nx == intv);
  wire          hit        = (adc_data >= trig_level) && (prev < trig_level);

  assign copy_req = (st == S_COPY);
  assign rd_data  = (int'(rd_addr) < NSAMP) ? mem[rd_addr] : '0;

  always_comb begin
    case (div_code)
      3'd1:    intv_sel = CW'(INTV1);
      3'd2:    intv_sel = CW'(INTV2);
      3'd3:    intv_sel = CW'(INTV3);
      3'd4:    intv_sel = CW'(INTV4);
      3'd5:    intv_sel = CW'(INTV5);
      default: intv_sel = CW'(INTV0);
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_INIT;
      cnt  <= '0;
      intv <= CW'(INTV0);
      idx  <= '0;
      prev <= '0;
    end else if (force_init) begin
      st   <= S_INIT;
      cnt  <= '0;
      idx  <= '0;
      prev <= '0;
    end else begin
      case (st)
        S_INIT: begin
          intv <= intv_sel;
          cnt  <= '0;
          idx  <= '0;
          prev <= '0;
          st   <= S_COUNT;
        end
        S_COUNT: begin
          if (take) begin
            cnt  <= '0;
            prev <= adc_data;
            if (idx < tp) idx <= idx + 1'b1;
            else if (hit) begin
              if (int'(tp) == LAST) st <= S_COPY;
              else begin
                idx <= tp + 1'b1;
                st  <= S_TRIG;
              end
            end
          end else cnt <= cnt_nx;
        end
        S_TRIG: begin
          if (take) begin
            cnt  <= '0;
            prev <= adc_data;
            if (int'(idx) == LAST) st <= S_COPY;
            else idx <= idx + 1'b1;
          end else cnt <= cnt_nx;
        end
        S_COPY: begin
          if (copy_done) begin
            cnt <= '0;
            st  <= S_DELAY;
          end
        end
        S_DELAY: begin
          if (cnt == CW'(DELAY_CYCLES - 1)) begin
            if (!single_mode) st <= S_INIT;
          end else cnt <= cnt_nx;
        end
        default: st <= S_INIT;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSAMP; k++) mem[k] <= '0;
    end else if (!force_init && take) begin
      if (st == S_TRIG) mem[idx] <= adc_data;
      else if (idx < tp) mem[idx] <= adc_data;
      else if (hit) mem[tp] <= adc_data;
      else begin
        for (int k = 0; k < LAST; k++) begin
          if (k + 1 < int'(tp)) mem[k] <= mem[k+1];
          else if (k + 1 == int'(tp)) mem[k] <= adc_data;
        end
      end
    end
  end

  int unsigned dwait;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dwait <= 0;
    else if (st == S_DELAY) dwait <= dwait + 1;
    else dwait <= 0;
  end

  assert_force_init_R9: assert property (@(negedge clk) disable iff (!rst_n)
    force_init |=> (st == S_INIT && idx == '0 && cnt == '0 && prev == '0));

  assert_idx_range_R5: assert property (@(negedge clk) disable iff (!rst_n)
    int'(idx) <= LAST);

  assert_trig_entry_R3: assert property (@(negedge clk) disable iff (!rst_n)
    (st == S_TRIG && $past(st) == S_COUNT) |->
      (idx == $past(tp) + 1'b1 && $past(adc_data) >= $past(trig_level)));

  assert_copy_entry_R5: assert property (@(negedge clk) disable iff (!rst_n)
    (st == S_COPY && $past(st) != S_COPY) |->
      (int'($past(idx)) == LAST || int'($past(tp)) == LAST));

  assert_delay_len_R7: assert property (@(negedge clk) disable iff (!rst_n)
    (st == S_INIT && $past(st) == S_DELAY && !$past(force_init)) |->
      dwait >= DELAY_CYCLES);

  assert_single_hold_R8: assert property (@(negedge clk) disable iff (!rst_n)
    (st == S_DELAY && single_mode && !force_init) |=> st == S_DELAY);
endmodule

// File: tb/test_capture_sequencer.sv
module test_capture_sequencer;
  localparam int NS  = 640;
  localparam int DLY = 300;

  logic       clk = 1'b0;
  logic       rst_n, single_mode, run_stop, settings_chg, copy_done, copy_req;
  logic [7:0] adc_data, trig_level, rd_data;
  logic [2:0] div_code;
  logic [9:0] trig_pos, rd_addr;
  bit         ramp_on = 0;
  bit         mon_done, done = 0;
  int         checks = 0, fails = 0;

  always #2 clk = ~clk;

  capture_sequencer #(.INTV0(13), .INTV1(11), .INTV2(9), .INTV3(5), .INTV4(7), .INTV5(1),
                      .DELAY_CYCLES(DLY)) i_capture_sequencer (
    .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .div_code(div_code),
    .trig_level(trig_level), .trig_pos(trig_pos), .single_mode(single_mode),
    .run_stop(run_stop), .settings_chg(settings_chg), .copy_done(copy_done),
    .rd_addr(rd_addr), .copy_req(copy_req), .rd_data(rd_data));

  typedef struct {int tp; int lvl; int step;} scn_t;
  scn_t q[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [7:0] v);
    rd_addr = 10'(a);
    #1;
    v = rd_data;
  endtask

  initial begin
    adc_data = 0;
    forever begin
      @(posedge clk); #1;
      adc_data = ramp_on ? adc_data + 8'd1 : 8'd0;
    end
  end

  task automatic start_cap(int code, int lvl, int tp, bit single);
    @(posedge clk); #1;
    run_stop = 1; ramp_on = 0;
    div_code = 3'(code); trig_level = 8'(lvl); trig_pos = 10'(tp); single_mode = single;
    repeat (3) @(posedge clk);
    #1; run_stop = 0; ramp_on = 1;
  endtask

  task automatic capture(int code, int lvl, int tp, bit single, int step);
    mon_done = 0;
    q.push_back('{tp, lvl, step});
    start_cap(code, lvl, tp, single);
    wait (mon_done);
  endtask

  task automatic wait_req(int lim, output int n);
    n = 0;
    while (!copy_req && n < lim) begin @(posedge clk); n++; end
  endtask

  initial begin
    forever begin
      scn_t d; int tpc, bad_pre, bad_post, drops;
      logic [7:0] b, v, e, s0, s1;
      wait (q.size() > 0);
      d = q.pop_front();
      do @(posedge clk); while (!copy_req);
      #1;
      tpc = (d.tp > NS - 1) ? NS - 1 : d.tp;
      rd(tpc, b);
      chk(int'(b) >= d.lvl, "R3 trigger sample at or above level", b, d.lvl);
      if (d.step == 1) chk(int'(b) == d.lvl, "R3 trigger on first crossing sample", b, d.lvl);
      if (tpc > 0) begin
        rd(tpc - 1, v);
        chk(int'(v) < d.lvl, "R3 previous sample below level", v, d.lvl - 1);
      end
      bad_pre = 0; bad_post = 0;
      for (int k = 0; k < NS; k++) begin
        rd(k, v);
        e = 8'(int'(b) + d.step * (k - tpc));
        if (v !== e && k < tpc && bad_pre == 0) begin
          bad_pre = 1;
          chk(0, "R2/R4 pre-trigger history", v, e);
        end
        if (v !== e && k > tpc && bad_post == 0) begin
          bad_post = 1;
          chk(0, "R2/R5 post-trigger samples", v, e);
        end
      end
      if (tpc > 0 && bad_pre == 0) chk(1, "R4", 0, 0);
      if (tpc < NS - 1 && bad_post == 0) chk(1, "R5", 0, 0);
      rd(0, s0); rd(tpc, s1);
      drops = 0;
      repeat (20) begin @(posedge clk); if (!copy_req) drops++; end
      chk(drops == 0, "R6 copy_req held while copy pending", drops, 0);
      #1; rd(0, v); rd(tpc, e);
      chk(v === s0 && e === s1, "R6 array frozen during copy", e, s1);
      @(posedge clk); #1 copy_done = 1;
      @(posedge clk);
      chk(copy_req == 0, "R6 copy_req released after copy_done", copy_req, 0);
      #1 copy_done = 0;
      mon_done = 1;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, hi;
    logic [7:0] v;
    rst_n = 0; run_stop = 1; settings_chg = 0; copy_done = 0; single_mode = 0;
    div_code = 3'd5; trig_level = 8'd100; trig_pos = 10'd0; rd_addr = 0;
    repeat (4) @(posedge clk);
    chk(copy_req == 0, "R1 copy_req low in reset", copy_req, 0);
    rd(0, v);   chk(v == 0, "R1 column 0 cleared", v, 0);
    rd(639, v); chk(v == 0, "R1 column 639 cleared", v, 0);
    @(posedge clk); #1 rst_n = 1;

    capture(5, 100, 320, 0, 1);
    wait_req(DLY + 2000, n);
    chk(n >= DLY && n <= DLY + 1300, "R7 free-running re-arm after delay", n, DLY);
    @(posedge clk); #1 copy_done = 1; single_mode = 1;
    @(posedge clk); #1 copy_done = 0;
    hi = 0;
    repeat (3 * DLY) begin @(posedge clk); if (copy_req) hi++; end
    chk(hi == 0, "R8 single mode stays paused", hi, 0);
    #1 single_mode = 0;
    wait_req(2000, n);
    chk(copy_req == 1, "R8 resumes after leaving single mode", copy_req, 1);
    @(posedge clk); #1 settings_chg = 1;
    @(posedge clk);
    chk(copy_req == 0, "R9 settings pulse abandons copy", copy_req, 0);
    #1 settings_chg = 0;
    wait_req(2000, n);
    chk(copy_req == 1, "R9 capture restarts after settings pulse", copy_req, 1);
    @(posedge clk); #1 copy_done = 1;
    @(posedge clk); #1 copy_done = 0;

    capture(4, 200, 10, 0, 7);
    capture(0, 50, 600, 0, 13);
    capture(3, 77, 200, 0, 5);
    capture(6, 30, 0, 1, 13);
    rd(0, v);
    chk(v >= 30 && v < 43, "R11 trigger sample in column 0", v, 30);
    capture(5, 100, 1000, 1, 1);
    rd(639, v); chk(v == 100, "R10 clamped trigger column 639", v, 100);
    rd(638, v); chk(v == 99, "R10 sample before clamped trigger", v, 99);

    start_cap(5, 0, 5, 0);
    hi = 0;
    repeat (3000) begin @(posedge clk); if (copy_req) hi++; end
    chk(hi == 0, "R12 zero level never triggers", hi, 0);

    @(posedge clk); #1 run_stop = 1; trig_level = 8'd100;
    hi = 0;
    repeat (2000) begin @(posedge clk); if (copy_req) hi++; end
    chk(hi == 0, "R9 run_stop blocks capture", hi, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule